// File: doc/BRIEF.md
# CSMA Channel Access Controller

This block decides when a low-power radio node may put a frame on the air. When the node asks to send, the controller listens first. It runs a sensing window on the current channel, made of a random number of channel-activity-detection probes. The radio performs each probe and answers idle or busy. The controller grants transmission only after a window in which every probe answered idle.

A 2-bit mode, captured when the request is accepted, selects the policy used when a window comes back busy:
- stay on the same channel and listen again;
- jump to a channel drawn at random;
- jump to the channel that has been busy least often, according to a per-channel occupancy history that the controller keeps.

A fourth mode skips sensing and grants at once. The request and the probe handshake are plain control pins. `tx_req` is a level that the controller looks at only while it is idle. The requester holds it until it sees `tx_grant` and then drops it. There is no back-pressure: the grant cannot be stalled, and a probe result is taken in the cycle `cad_done` is high.

Top module: `csma_access_ctrl`

## Requirements
- R1: After reset, `cad_start` and `tx_grant` are low, `chan_idx` is 0, the controller is idle, and every occupancy count is 0.
- R2: Each sensing window runs between 1 and MAX_PROBES probes. The count is drawn from a free-running 16-bit LFSR at the start of each window.
- R3: Each probe is a single-cycle `cad_start` pulse. No new pulse is issued until `cad_done` has answered the previous one.
- R4: A window is clear only if every probe in it returned `cad_busy`=0; one busy answer makes the window busy. In modes 1, 2 and 3, `tx_grant` follows only a clear window.
- R5: In mode 1 (stay), `chan_idx` does not change while a request is being served. Busy windows repeat on the same channel until one is clear.
- R6: In mode 2 (random hop), each busy window moves `chan_idx` to a channel drawn from the LFSR among the NUM_CH channels, and a new window starts there.
- R7: In mode 3 (least occupied), a busy window moves to the channel with the smallest occupancy count; ties go to the lowest index. The busy channel itself is kept only when its count is strictly below every other channel's.
- R8: At the end of each window, the occupancy count of the channel just sensed goes up by one if the window was busy and down by one if it was clear. It saturates at its maximum and does not go below 0. The mode 3 choice uses the counts from before this update.
- R9: `tx_grant` is high for exactly one cycle, with `chan_idx` showing the granted channel. The controller then returns to idle. `tx_req` has no effect while a request is being served.
- R10: In mode 0, `tx_grant` rises in the cycle after the request is accepted, and no probe is issued.
- R11: The mode is sampled only when a request is accepted. Changing `mode` during sensing does not change the policy in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Request to transmit, held until `tx_grant` |
| mode | input | 2 | Policy: 0 off, 1 stay, 2 random hop, 3 least occupied |
| cad_start | output | 1 | One-cycle pulse that starts a probe |
| cad_done | input | 1 | Probe finished; `cad_busy` is valid in this cycle |
| cad_busy | input | 1 | Probe result, 1 = activity found |
| chan_idx | output | 3 | Channel being sensed or granted |
| tx_grant | output | 1 | One-cycle permission to transmit on `chan_idx` |

## Verification
The bench builds the controller with MAX_PROBES set to 6, keeping NUM_CH at 8 and OCC_W at 8. A short window keeps the whole range of probe counts within a hundred requests, so the bench can observe both the shortest window of one probe and the longest.

The bench also steers mode 3 through a fixed sequence of channel occupancy. This sequence produces lowest-index tie breaks, a busy channel that is kept because it is strictly least occupied, and the floor at zero. A reset in the middle of the run then shows that the history has been cleared.

// File: rtl/csma_pkg.sv
package csma_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_STAY  = 2'd1,
    MODE_RAND  = 2'd2,
    MODE_LEAST = 2'd3
  } csma_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_GRANT = 3'd4
  } csma_state_e;

endpackage

// File: rtl/csma_lfsr.sv
// Free-running Fibonacci LFSR; TAPS is the feedback mask over the state bits.
module csma_lfsr #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  SEED = 'hACE1,
  parameter logic [W-1:0]  TAPS = 'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], ^(q & TAPS)};
  end

endmodule

// File: rtl/csma_occ_table.sv
// Per-channel saturating busy history and least-occupied channel search.
module csma_occ_table #(
  parameter int NUM_CH = 8,
  parameter int OCC_W  = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic            upd_busy,
  input  logic [CH_W-1:0] upd_ch,
  input  logic [CH_W-1:0] cur_ch,
  output logic [CH_W-1:0] least_ch
);

  logic [OCC_W-1:0] occ_v [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [OCC_W-1:0] cnt_q;
    logic             hit;
    assign hit = upd_en && (upd_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (hit) begin
        if (upd_busy) begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
    assign occ_v[g] = cnt_q;
  end

  // Minimum over the other channels, lowest index on ties; keep the
  // current channel only when it is strictly below that minimum.
  always_comb begin
    logic             found;
    logic [OCC_W-1:0] min_v;
    logic [CH_W-1:0]  min_c;
    found = 1'b0;
    min_v = '1;
    min_c = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (CH_W'(i) != cur_ch && (!found || occ_v[i] < min_v)) begin
        found = 1'b1;
        min_v = occ_v[i];
        min_c = CH_W'(i);
      end
    end
    least_ch = (occ_v[cur_ch] < min_v) ? cur_ch : min_c;
  end

endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl
  import csma_pkg::*;
#(
  parameter int                 NUM_CH     = 8,
  parameter int                 MAX_PROBES = 20,
  parameter int                 OCC_W      = 8,
  parameter int                 LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]  LFSR_SEED  = 'hACE1,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS  = 'hB400
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_req,
  input  logic [1:0]                 mode,
  output logic                       cad_start,
  input  logic                       cad_done,
  input  logic                       cad_busy,
  output logic [$clog2(NUM_CH)-1:0]  chan_idx,
  output logic                       tx_grant
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int CNT_W = $clog2(MAX_PROBES + 1);

  csma_state_e       state_q;
  csma_mode_e        mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              in_idle;

  logic [LFSR_W-1:0] rnd;
  logic [LFSR_W-1:0] cnt_mod;
  logic [LFSR_W-1:0] rnd_hi;
  logic [CNT_W-1:0]  draw_cnt;
  logic [CH_W-1:0]   rand_ch;
  logic [CH_W-1:0]   least_ch;
  logic [CH_W-1:0]   next_ch;
  logic              eval_st;

  csma_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (rnd)
  );

  // Probe count 1..MAX_PROBES from the low end; hop target from the high end.
  assign cnt_mod  = rnd % LFSR_W'(MAX_PROBES);
  assign draw_cnt = CNT_W'(cnt_mod) + CNT_W'(1);
  assign rnd_hi   = rnd >> (LFSR_W / 2);
  assign rand_ch  = CH_W'(rnd_hi % LFSR_W'(NUM_CH));

  assign eval_st = (state_q == ST_EVAL);

  csma_occ_table #(
    .NUM_CH (NUM_CH),
    .OCC_W  (OCC_W),
    .CH_W   (CH_W)
  ) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (eval_st),
    .upd_busy (busy_q),
    .upd_ch   (chan_q),
    .cur_ch   (chan_q),
    .least_ch (least_ch)
  );

  always_comb begin
    case (mode_q)
      MODE_RAND:  next_ch = rand_ch;
      MODE_LEAST: next_ch = least_ch;
      default:    next_ch = chan_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_OFF;
      chan_q  <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tx_req) begin
            mode_q <= csma_mode_e'(mode);
            busy_q <= 1'b0;
            left_q <= draw_cnt;
            state_q <= (csma_mode_e'(mode) == MODE_OFF) ? ST_GRANT : ST_PROBE;
          end
        end
        ST_PROBE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cad_done) begin
            busy_q  <= busy_q | cad_busy;
            left_q  <= left_q - CNT_W'(1);
            state_q <= (left_q == CNT_W'(1)) ? ST_EVAL : ST_PROBE;
          end
        end
        ST_EVAL: begin
          if (!busy_q) begin
            state_q <= ST_GRANT;
          end else begin
            chan_q  <= next_ch;
            left_q  <= draw_cnt;
            busy_q  <= 1'b0;
            state_q <= ST_PROBE;
          end
        end
        ST_GRANT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_idle   = (state_q == ST_IDLE);
  assign cad_start = (state_q == ST_PROBE);
  assign tx_grant  = (state_q == ST_GRANT);
  assign chan_idx  = chan_q;

endmodule

// File: rtl/csma_access_chk.sv
module csma_access_chk #(
  parameter int MAX_PROBES = 20,
  parameter int CNT_W      = 5,
  parameter int CH_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cad_start,
  input logic             cad_done,
  input logic             cad_busy,
  input logic             tx_grant,
  input logic [CH_W-1:0]  chan_idx,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] left_q,
  input logic             in_idle
);

  logic outstanding;
  logic last_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      last_idle   <= 1'b0;
    end else begin
      if (cad_start)     outstanding <= 1'b1;
      else if (cad_done) outstanding <= 1'b0;
      if (cad_done) last_idle <= !cad_busy;
    end
  end

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cad_start |=> !cad_start);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cad_start |-> !outstanding);

  a_r9_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  a_r4_clear_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && mode_q != 2'd0) |-> last_idle);

  a_r5_stay_on_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && mode_q == 2'd1) |=> $stable(chan_idx));

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cad_start |-> (left_q >= CNT_W'(1) && left_q <= CNT_W'(MAX_PROBES)));

  a_r10_off_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && mode_q == 2'd0) |-> !cad_start);

endmodule

bind csma_access_ctrl csma_access_chk #(
  .MAX_PROBES (MAX_PROBES),
  .CNT_W      (CNT_W),
  .CH_W       (CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cad_start (cad_start),
  .cad_done  (cad_done),
  .cad_busy  (cad_busy),
  .tx_grant  (tx_grant),
  .chan_idx  (chan_idx),
  .mode_q    (mode_q),
  .left_q    (left_q),
  .in_idle   (in_idle)
);

// File: tb/csma_access_ctrl_bench.sv
module csma_access_ctrl_bench;

  localparam int NCH  = 8;
  localparam int MAXP = 6;
  localparam int NV   = 11;

  // {mode[21:20], busy mask[19:12], busy answers[11:4] (255 = forever), expected channel[3:0]}
  // expected 8 = any channel outside the mask, 9 = same channel as the previous grant
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'd0,   4'd0},
    {2'd3, 8'h03, 8'hFF,  4'd2},
    {2'd3, 8'h04, 8'hFF,  4'd3},
    {2'd3, 8'h08, 8'hFF,  4'd4},
    {2'd3, 8'h30, 8'hFF,  4'd6},
    {2'd3, 8'h40, 8'd1,   4'd7},
    {2'd3, 8'h80, 8'd1,   4'd7},
    {2'd1, 8'h80, 8'd3,   4'd7},
    {2'd2, 8'h80, 8'hFF,  4'd8},
    {2'd1, 8'h00, 8'd0,   4'd9},
    {2'd0, 8'hFF, 8'hFF,  4'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       cad_done = 1'b0;
  logic       cad_busy = 1'b0;
  logic       cad_start;
  logic       tx_grant;
  logic [2:0] chan_idx;

  always #5 clk = ~clk;

  csma_access_ctrl #(
    .NUM_CH     (NCH),
    .MAX_PROBES (MAXP)
  ) u_csma_access_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .mode      (mode),
    .cad_start (cad_start),
    .cad_done  (cad_done),
    .cad_busy  (cad_busy),
    .chan_idx  (chan_idx),
    .tx_grant  (tx_grant)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // radio model state
  logic [7:0] busy_mask = 8'h00;
  int         busy_left = 0;
  bit         pend = 1'b0;
  int         dly = 0;
  int         req_probes = 0;
  int         win_probes = 0;
  bit         last_busy = 1'b0;
  logic [2:0] prev_chan = 3'd0;
  int         cur_mode = 0;
  int         grant_ch = 0;
  int         prev_grant = 0;
  int         lat = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Radio model: answers each probe two cycles after cad_start.
  initial begin
    forever begin
      @(negedge clk);
      cad_done = 1'b0;
      cad_busy = 1'b0;
      if (!rst_n) begin
        pend = 1'b0;
        prev_chan = chan_idx;
      end else begin
        if (chan_idx != prev_chan) begin
          if (cur_mode == 3)
            check(win_probes >= 1 && win_probes <= MAXP, "R2 window length", win_probes, MAXP);
          win_probes = 0;
          prev_chan = chan_idx;
        end
        if (cad_start) begin
          check(!pend, "R3 probe before answer", int'(pend), 0);
          pend = 1'b1;
          dly = 1;
          req_probes++;
          win_probes++;
        end else if (pend) begin
          if (dly > 0) begin
            dly--;
          end else begin
            bit b;
            pend = 1'b0;
            b = busy_mask[chan_idx] && (busy_left > 0);
            if (b && busy_left < 255) busy_left--;
            cad_done = 1'b1;
            cad_busy = b;
            last_busy = b;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL R9 watchdog: actual=%0d expected<%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run_req(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    tx_req = 1'b1;
    req_probes = 0;
    win_probes = 0;
    last_busy = 1'b0;
    cur_mode = int'(m);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!tx_grant && lat < 4000);
    grant_ch = int'(chan_idx);
    tx_req = 1'b0;
    check(lat < 4000, "R9 grant reached", lat, 4000);
    @(negedge clk);
    check(!tx_grant, "R9 grant one cycle", int'(tx_grant), 0);
  endtask

  initial begin
    int pmin;
    int pmax;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!cad_start && !tx_grant, "R1 outputs low in reset", int'({cad_start, tx_grant}), 0);
    check(chan_idx == 3'd0, "R1 channel zero", int'(chan_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cad_start && !tx_grant, "R1 idle after reset", int'({cad_start, tx_grant}), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      int exp_ch;
      string tag;
      v = VEC[i];
      busy_mask = v[19:12];
      busy_left = int'(v[11:4]);
      run_req(v[21:20]);
      case (v[21:20])
        2'd0: tag = "R10 off mode";
        2'd1: tag = "R5 stay mode";
        2'd2: tag = "R6 random hop";
        default: tag = "R7 least occupied";
      endcase
      if (v[3:0] == 4'd8) begin
        check(!busy_mask[grant_ch[2:0]], tag, grant_ch, -1);
      end else begin
        exp_ch = (v[3:0] == 4'd9) ? prev_grant : int'(v[3:0]);
        check(grant_ch == exp_ch, tag, grant_ch, exp_ch);
      end
      if (v[21:20] == 2'd0) begin
        check(req_probes == 0 && lat == 1, "R10 immediate grant", req_probes * 100 + lat, 1);
      end else begin
        check(req_probes > 0 && !last_busy, "R4 clear window before grant", int'(last_busy), 0);
      end
      if (i == 6) check(grant_ch == 7, "R8 floor and strict keep", grant_ch, 7);
      prev_grant = grant_ch;
    end

    // R11: mode changed during sensing is ignored
    busy_mask = 8'h01 << prev_grant;
    busy_left = 2;
    fork
      run_req(2'd1);
      begin
        @(negedge clk);
        @(negedge clk);
        mode = 2'd0;
      end
    join
    check(req_probes >= 3 && grant_ch == prev_grant, "R11 mode sampled on accept",
          req_probes, 3);

    // R2: probe count spread over many clear windows
    busy_mask = 8'h00;
    pmin = 1000;
    pmax = 0;
    for (int k = 0; k < 100; k++) begin
      run_req(2'd1);
      if (req_probes < pmin) pmin = req_probes;
      if (req_probes > pmax) pmax = req_probes;
    end
    check(pmin == 1, "R2 shortest window", pmin, 1);
    check(pmax == MAXP, "R2 longest window", pmax, MAXP);

    // R1: reset clears history and channel
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(chan_idx == 3'd0 && !tx_grant, "R1 channel after reset", int'(chan_idx), 0);
    rst_n = 1'b1;
    busy_mask = 8'h01;
    busy_left = 255;
    run_req(2'd3);
    check(grant_ch == 1, "R1 history cleared (R7 tie)", grant_ch, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule